// File: doc/BRIEF.md
# Real-Time Clock Calendar Core

This block keeps time of day and the calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It also holds one alarm byte each for seconds, minutes and hours. A one-clock-wide pulse on `tick` arrives once per second and starts an update cycle. The update-in-progress flag stays high for `UIP_CYCLES` clocks, and then the whole time and date advance in a single clock edge. On that same edge the new time is compared against the alarm bytes, and the update-ended and alarm flags are raised.

A host reaches every register through a byte-addressed port. Reads are combinational from `addr`, and writes take effect on the clock edge where `cs` and `we` are both high. Through control register B the host can freeze counting while it loads a new time. The same register chooses BCD or binary coding and 12- or 24-hour coding, and it enables the interrupt sources. The flag register clears when it is read, and the `irq` output follows the summary interrupt flag.

Top module: `rtc_core`

## Requirements
- R1: Addresses 0x0 to 0x9 hold seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, day of week (1 to 7), day of month, month and year, in that order. After reset the time reads 00:00:00, day of week, date and month read 0x01, and year and alarms read 0x00.
- R2: Register A (address 0xA) bit 7 reads 1 from the clock edge after an accepted `tick` until the edge that advances the time, `UIP_CYCLES` clocks in all, and reads 0 otherwise. Writes to bit 7 are ignored. Bits 6:0 are read/write and reset to 0x26. The time bytes change only at the end of an update or on a host write.
- R3: Writing 1 to register B (address 0xB) bit 7 aborts any update in progress without changing the time, and ticks are ignored while that bit is 1. After a 0 is written, counting resumes at one step per tick.
- R4: Register B bit 2 selects the coding of every time byte: 1 means binary, 0 means BCD. It resets to 0. In both codings, seconds roll from 59 to 0 and carry into minutes, minutes carry into hours, and hours carry into the date.
- R5: Register B bit 1 selects the hour mode: 1 means 24-hour (hours 0 to 23) and 0 means 12-hour. It resets to 1, so register B resets to 0x02. In 12-hour mode, hours bit 7 is the PM flag and hours run 1 to 12. So 11 AM goes to 12 PM (BCD 0x92), 12 PM goes to 1 PM (0x81), and 11 PM goes to 12 AM (0x12) with a date step.
- R6: When the hours roll over, the day of week steps from 7 back to 1. The date wraps after 30 days in April, June, September and November, and after 31 days in the other long months. February has 29 days when the year is divisible by four and 28 otherwise. The month wraps from 12 to 1, and the year wraps from 99 to 0.
- R7: Every completed update sets UF (register C bit 4). AF (bit 5) is set when the new seconds, minutes and hours each equal their alarm byte. An alarm byte whose bits 7:6 are both 1 matches any value.
- R8: IRQF (register C bit 7) and the `irq` pin are 1 exactly when AF is set with AIE (register B bit 5) at 1, or UF is set with UIE (register B bit 4) at 1. Both enables reset to 0.
- R9: Register C (address 0xC) reads as {IRQF, 0, AF, UF, 4'b0000}, and a read clears all of its flags. Writes to it are ignored.
- R10: Register D (address 0xD) reads as {`power_ok`, 7'b0} and ignores writes. Addresses 0xE and 0xF read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse, once per second |
| cs | input | 1 | Host access strobe |
| we | input | 1 | Write when 1, read when 0 |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| power_ok | input | 1 | Backup power good indication |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several invariants: the freeze bit and an active update never overlap, the seconds byte stays put outside updates and host writes, every step moves the seconds and raises UF, a read of register C leaves the flags clear, and `irq` is never high without a pending flag. Only the bench scenarios can show that calendar arithmetic is correct across formats. These cover month lengths, leap years, the year wrap, 12-hour PM transitions, alarm matches including wildcards, the exact register read values, and the freeze and abort sequences seen from the host port.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int UIP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cs,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       power_ok,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int CW = $clog2(UIP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(UIP_CYCLES - 1);

  logic [7:0] tm [10];
  logic [6:0] ra;
  logic [7:0] rb;
  logic       busy, af, uf;
  logic [CW-1:0] cnt;

  wire dm    = rb[2];
  wire h24m  = rb[1];
  wire wr    = cs && we;
  wire rd_c  = cs && !we && addr == 4'hC;
  wire abort = wr && addr == 4'hB && wdata[7];
  wire go    = tick && !rb[7] && !busy;
  wire upd   = busy && cnt == LAST && !abort;
  wire irqf  = (af && rb[5]) || (uf && rb[4]);
  assign irq = irqf;

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    dec = bin ? b[6:0] : 7'({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [6:0] t, o;
    t = v / 7'd10;
    o = v % 7'd10;
    enc = bin ? {1'b0, v} : {t[3:0], o[3:0]};
  endfunction

  function automatic logic [6:0] mdays(input logic [6:0] m, input logic [6:0] y);
    case (m)
      7'd2:                       mdays = (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    mdays = 7'd30;
      default:                    mdays = 7'd31;
    endcase
  endfunction

  function automatic logic hit(input logic [7:0] v, input logic [7:0] al);
    hit = (al[7:6] == 2'b11) || (al == v);
  endfunction

  logic [6:0] s, mi, h, h12, dw, dt, mo, yr, nh12;
  logic [7:0] n_s, n_m, n_h, n_dw, n_dt, n_mo, n_yr, t8;
  logic       c_day;

  always_comb begin
    s  = dec(tm[0], dm);
    mi = dec(tm[2], dm);
    h12 = dec({1'b0, tm[4][6:0]}, dm);
    if (h24m) h = dec(tm[4], dm);
    else      h = ((h12 == 7'd12) ? 7'd0 : h12) + (tm[4][7] ? 7'd12 : 7'd0);
    dw = dec(tm[6], dm);
    dt = dec(tm[7], dm);
    mo = dec(tm[8], dm);
    yr = dec(tm[9], dm);
    c_day = 1'b0;
    if (s >= 7'd59) begin
      s = 7'd0;
      if (mi >= 7'd59) begin
        mi = 7'd0;
        if (h >= 7'd23) begin
          h = 7'd0;
          c_day = 1'b1;
        end else h = h + 7'd1;
      end else mi = mi + 7'd1;
    end else s = s + 7'd1;
    if (c_day) begin
      dw = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
      if (dt >= mdays(mo, yr)) begin
        dt = 7'd1;
        if (mo >= 7'd12) begin
          mo = 7'd1;
          yr = (yr >= 7'd99) ? 7'd0 : yr + 7'd1;
        end else mo = mo + 7'd1;
      end else dt = dt + 7'd1;
    end
    nh12 = (h == 7'd0) ? 7'd12 : (h > 7'd12) ? h - 7'd12 : h;
    t8   = enc(nh12, dm);
    n_h  = h24m ? enc(h, dm) : {h >= 7'd12, t8[6:0]};
    n_s  = enc(s, dm);
    n_m  = enc(mi, dm);
    n_dw = enc(dw, dm);
    n_dt = enc(dt, dm);
    n_mo = enc(mo, dm);
    n_yr = enc(yr, dm);
  end

  wire alarm = hit(n_s, tm[1]) && hit(n_m, tm[3]) && hit(n_h, tm[5]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) tm[i] <= 8'h00;
      tm[6] <= 8'h01;
      tm[7] <= 8'h01;
      tm[8] <= 8'h01;
      ra <= 7'h26;
      rb <= 8'h02;
      busy <= 1'b0;
      cnt <= '0;
      af <= 1'b0;
      uf <= 1'b0;
    end else begin
      if (wr && addr < 4'd10) tm[addr] <= wdata;
      if (wr && addr == 4'hA) ra <= wdata[6:0];
      if (wr && addr == 4'hB) rb <= wdata;
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (abort || cnt == LAST) busy <= 1'b0;
      end
      if (rd_c) begin
        af <= 1'b0;
        uf <= 1'b0;
      end
      if (upd) begin
        tm[0] <= n_s;  tm[2] <= n_m;  tm[4] <= n_h;
        tm[6] <= n_dw; tm[7] <= n_dt; tm[8] <= n_mo; tm[9] <= n_yr;
        uf <= 1'b1;
        if (alarm) af <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr < 4'd10) rdata = tm[addr];
    else case (addr)
      4'hA: rdata = {busy, ra};
      4'hB: rdata = rb;
      4'hC: rdata = {irqf, 1'b0, af, uf, 4'b0000};
      4'hD: rdata = {power_ok, 7'b0};
      default: rdata = 8'h00;
    endcase
  end

  AST_SET_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    rb[7] |-> !busy); // R3
  AST_SEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !(wr && addr == 4'h0)) |=> $stable(tm[0])); // R2
  AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> tm[0] != $past(tm[0])); // R4
  AST_UF_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> uf); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !upd) |=> (!af && !uf)); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (af || uf)); // R8
endmodule

// File: tb/rtc_core_test.sv
module rtc_core_test;
  localparam int UIP = 4;
  logic clk = 0, rst_n = 0, tick = 0, cs = 0, we = 0, power_ok = 1, probe = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq;
  int total = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [7:0] e; bit pin; bit ign; string tag; } item_t;
  item_t q[$];

  rtc_core #(.UIP_CYCLES(UIP)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .power_ok(power_ok), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  always @(negedge clk) if (probe && q.size() > 0) begin
    item_t it;
    logic [7:0] v;
    it = q.pop_front();
    v = it.pin ? {7'b0, irq} : rdata;
    if (!it.ign) begin
      total++;
      if (v !== it.e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", it.tag, v, it.e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 cs = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 cs = 0; we = 0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1 cs = 1; we = 0; addr = a; probe = 1;
    q.push_back('{e: e, pin: 0, ign: 0, tag: tag});
    @(posedge clk); #1 cs = 0; probe = 0;
  endtask

  task automatic rd_clear();
    @(posedge clk); #1 cs = 1; we = 0; addr = 4'hC; probe = 1;
    q.push_back('{e: 8'h00, pin: 0, ign: 1, tag: "clr"});
    @(posedge clk); #1 cs = 0; probe = 0;
  endtask

  task automatic chk_pin(input logic e, input string tag);
    @(posedge clk); #1 probe = 1;
    q.push_back('{e: {7'b0, e}, pin: 1, ign: 0, tag: tag});
    @(posedge clk); #1 probe = 0;
  endtask

  task automatic pulse();
    @(posedge clk); #1 tick = 1;
    @(posedge clk); #1 tick = 0;
  endtask

  task automatic step();
    pulse();
    repeat (UIP + 2) @(posedge clk);
  endtask

  task automatic set_clock(input logic [7:0] mode, input logic [7:0] hr, mn, sc, dt, mo, yr);
    wr(4'hB, mode | 8'h80);
    wr(4'h4, hr); wr(4'h2, mn); wr(4'h0, sc);
    wr(4'h7, dt); wr(4'h8, mo); wr(4'h9, yr);
    wr(4'hB, mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state
    chk(4'h0, 8'h00, "R1 sec reset");
    chk(4'h6, 8'h01, "R1 dow reset");
    chk(4'h7, 8'h01, "R1 date reset");
    chk(4'h8, 8'h01, "R1 month reset");
    chk(4'h9, 8'h00, "R1 year reset");
    chk(4'hA, 8'h26, "R2 regA reset");
    chk(4'hB, 8'h02, "R5 regB reset");
    chk(4'hC, 8'h00, "R9 regC reset");
    chk(4'hD, 8'h80, "R10 regD power good");
    chk_pin(1'b0, "R8 irq reset");
    // full wrap in BCD
    set_clock(8'h02, 8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
    wr(4'h6, 8'h07);
    step();
    chk(4'h0, 8'h00, "R4 sec wrap");
    chk(4'h2, 8'h00, "R4 min wrap");
    chk(4'h4, 8'h00, "R4 hour wrap");
    chk(4'h6, 8'h01, "R6 dow wrap");
    chk(4'h7, 8'h01, "R6 date wrap");
    chk(4'h8, 8'h01, "R6 month wrap");
    chk(4'h9, 8'h00, "R6 year wrap");
    // update in progress
    pulse();
    chk(4'hA, 8'hA6, "R2 UIP high");
    repeat (UIP + 2) @(posedge clk);
    chk(4'hA, 8'h26, "R2 UIP low");
    chk(4'h0, 8'h01, "R2 step done");
    // freeze and abort
    wr(4'hB, 8'h82);
    step();
    chk(4'h0, 8'h01, "R3 frozen");
    chk(4'hA, 8'h26, "R3 no UIP when frozen");
    wr(4'hB, 8'h02);
    step();
    chk(4'h0, 8'h02, "R3 resumed");
    pulse();
    wr(4'hB, 8'h82);
    repeat (UIP + 4) @(posedge clk);
    chk(4'h0, 8'h02, "R3 aborted");
    chk(4'hA, 8'h26, "R3 abort clears UIP");
    wr(4'hB, 8'h02);
    step();
    chk(4'h0, 8'h03, "R3 after abort");
    // month lengths and leap years
    set_clock(8'h02, 8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24);
    step();
    chk(4'h7, 8'h29, "R6 leap feb29");
    chk(4'h8, 8'h02, "R6 leap month");
    set_clock(8'h02, 8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h24);
    step();
    chk(4'h7, 8'h01, "R6 leap mar1");
    chk(4'h8, 8'h03, "R6 leap month3");
    set_clock(8'h02, 8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h23);
    step();
    chk(4'h7, 8'h01, "R6 common feb");
    chk(4'h8, 8'h03, "R6 common month3");
    set_clock(8'h02, 8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h23);
    step();
    chk(4'h8, 8'h05, "R6 april 30");
    // binary coding
    set_clock(8'h06, 8'h17, 8'h05, 8'h3B, 8'h0A, 8'h03, 8'h10);
    step();
    chk(4'h0, 8'h00, "R4 bin sec");
    chk(4'h2, 8'h06, "R4 bin min");
    set_clock(8'h06, 8'h17, 8'h3B, 8'h3B, 8'h1F, 8'h0C, 8'h63);
    step();
    chk(4'h4, 8'h00, "R4 bin hour");
    chk(4'h7, 8'h01, "R6 bin date");
    chk(4'h9, 8'h00, "R6 bin year");
    // 12-hour mode
    set_clock(8'h00, 8'h11, 8'h59, 8'h59, 8'h10, 8'h05, 8'h20);
    step();
    chk(4'h4, 8'h92, "R5 11am to 12pm");
    set_clock(8'h00, 8'h92, 8'h59, 8'h59, 8'h10, 8'h05, 8'h20);
    step();
    chk(4'h4, 8'h81, "R5 12pm to 1pm");
    set_clock(8'h00, 8'h91, 8'h59, 8'h59, 8'h10, 8'h05, 8'h20);
    step();
    chk(4'h4, 8'h12, "R5 11pm to 12am");
    chk(4'h7, 8'h11, "R5 date step");
    // alarms and flags
    set_clock(8'h02, 8'h10, 8'h20, 8'h29, 8'h10, 8'h05, 8'h20);
    wr(4'h1, 8'h30); wr(4'h3, 8'h20); wr(4'h5, 8'h10);
    rd_clear();
    wr(4'hB, 8'h22);
    step();
    chk_pin(1'b1, "R8 alarm irq");
    chk(4'hC, 8'hB0, "R7 alarm match");
    chk(4'hC, 8'h00, "R9 cleared by read");
    chk_pin(1'b0, "R9 irq cleared");
    wr(4'h1, 8'hC0); wr(4'h3, 8'hC0); wr(4'h5, 8'hC0);
    step();
    chk(4'hC, 8'hB0, "R7 wildcard match");
    wr(4'h1, 8'h45);
    wr(4'hB, 8'h12);
    step();
    chk_pin(1'b1, "R8 update irq");
    chk(4'hC, 8'h90, "R7 no alarm match");
    wr(4'hB, 8'h02);
    wr(4'h1, 8'hC0);
    step();
    chk_pin(1'b0, "R8 disabled irq");
    chk(4'hC, 8'h30, "R8 flags without irqf");
    // read-only registers and unused addresses
    power_ok = 0;
    chk(4'hD, 8'h00, "R10 power bad");
    wr(4'hC, 8'hFF); wr(4'hD, 8'hFF);
    chk(4'hC, 8'h00, "R9 write ignored");
    chk(4'hD, 8'h00, "R10 write ignored");
    wr(4'hA, 8'hFF);
    chk(4'hA, 8'h7F, "R2 uip not writable");
    chk(4'hE, 8'h00, "R10 unused address");
    power_ok = 1;
    chk(4'hD, 8'h80, "R10 power restored");
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule